// File: doc/BRIEF.md
# Sub-page write permission walker

This block decides whether a guest write to a 4 KB page may proceed when write protection is tracked per 128-byte slice of that page. A page holds 32 such slices, and each slice has its own permission bit kept in a four-level in-memory table. A request carries the guest physical address, the write/read kind, two attributes taken from the page-level leaf entry (the sub-page protection flag and the page writable flag), and a flag for the exit-qualification word. A global enable and the table root address come in on configuration inputs.

When the request needs no sub-page check, the block answers at once from the page-level attributes. Otherwise it walks the table one level at a time through a memory read port that allows one outstanding read. Each read may take any number of cycles. It reports allow, permission violation, table miss or table misconfiguration. For the last two it also gives an exit-qualification word and the faulting address. Requests use a valid/ready handshake, and each result is marked by a one-cycle done pulse.

Top module: `spg_walker`

## Requirements
- R1: When the request is a read, or `cfg_enable` is 0, or `req_leaf_prot` is 0, no table read is issued, and done follows one cycle after acceptance. The result is allow (code 0) for a read or a writable page, and violation (code 1) for a write to a non-writable page.
- R2: A write with enable and protection flag set to a page whose `req_leaf_writable` is 1 gives allow (code 0) one cycle after acceptance, with no table read.
- R3: A protected write to a non-writable page reads four entries in order: level 4, 3, 2, then 1. Each entry address is the table base with 8 × index added, using index gpa[47:39], gpa[38:30], gpa[29:21] and gpa[20:12] in turn. The level-4 base is `cfg_root`, and each later base is bits PA_W-1:12 of the entry just read.
- R4: In a level 4, 3 or 2 entry, any set bit in 11:1 or in 63:PA_W gives misconfiguration (code 3). This takes priority over the present bit (bit 0), and the walk stops there.
- R5: A level 4, 3 or 2 entry with clean reserved bits and bit 0 clear gives a miss (code 2). No deeper level is read.
- R6: A level-1 entry with any odd bit (2i+1) set gives misconfiguration (code 3).
- R7: For a clean level-1 entry, bit 2×gpa[11:7] set gives allow (code 0) and clear gives violation (code 1).
- R8: With done, `exit_qual` bit 11 is 1 for a miss and 0 for a misconfiguration, and bit 12 equals the request's `req_nmi_unblock`. All other bits are 0. `fault_gpa` equals the request address. For allow and violation, both outputs are zero.
- R9: `req_ready` is high only while no request is in progress. The memory request holds its address until `mem_req_ready`, and a response is taken on `mem_rsp_valid` whatever its delay.
- R10: `done` is a single-cycle pulse, and `result` is valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global sub-page protection enable |
| cfg_root | input | PA_W-12 | Level-4 table base, address bits PA_W-1:12 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_gpa | input | GPA_W | Guest physical address of the access |
| req_write | input | 1 | Access is a write |
| req_leaf_prot | input | 1 | Sub-page protection flag from the page leaf entry |
| req_leaf_writable | input | 1 | Page-level writable flag |
| req_nmi_unblock | input | 1 | Copied to exit_qual bit 12 on a fault |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read request taken |
| mem_req_addr | output | PA_W | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 allow, 1 violation, 2 miss, 3 misconfiguration |
| exit_qual | output | 64 | Exit-qualification word for miss and misconfiguration |
| fault_gpa | output | GPA_W | Faulting guest address for miss and misconfiguration |

## Verification
The bench builds the walker with its default parameters, PA_W = 46 and GPA_W = 48. The 48-bit address covers every index field of all four levels. The 46-bit physical width leaves bits 63:46 reserved in every pointer entry, so a stray bit 46 can be tested as a misconfiguration separately from the low reserved field. The table sits in a sparse model that returns zero for entries never written, so any level can be made to miss. The read latency is varied between runs so the handshake is exercised with both immediate and delayed replies.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int LVL_N   = 4;
  localparam int IDX_W   = 9;
  localparam int SUB_N   = 32;
  localparam int SUB_W   = $clog2(SUB_N);
  localparam int Q_MISS  = 11;
  localparam int Q_NMI   = 12;

  typedef enum logic [1:0] {
    RES_ALLOW  = 2'd0,
    RES_VIOL   = 2'd1,
    RES_MISS   = 2'd2,
    RES_MISCFG = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } st_e;
endpackage

// File: rtl/spg_entry_addr.sv
module spg_entry_addr
  import spg_pkg::*;
#(
  parameter int PA_W = 46
) (
  input  logic [PA_W-13:0]            base,
  input  logic [1:0]                  level,
  input  logic [LVL_N*IDX_W-1:0]      idx_src,
  output logic [PA_W-1:0]             entry_addr
);
  logic [IDX_W-1:0] idx_sel [LVL_N];

  for (genvar l = 0; l < LVL_N; l++) begin : g_idx
    assign idx_sel[l] = idx_src[l*IDX_W +: IDX_W];
  end

  // table base is 4 KB aligned and index*8 stays below 4 KB
  assign entry_addr = {base, idx_sel[level], 3'b000};
endmodule

// File: rtl/spg_entry_check.sv
module spg_entry_check
  import spg_pkg::*;
#(
  parameter int PA_W = 46
) (
  input  logic [63:0]       entry,
  input  logic              is_leaf,
  input  logic [SUB_W-1:0]  sub_idx,
  output logic              bad,
  output logic              present,
  output logic              perm,
  output logic [PA_W-13:0]  next_base
);
  localparam logic [63:0] PA_MASK  = (64'd1 << PA_W) - 64'd1;
  localparam logic [63:0] RSV_MASK = ~PA_MASK | 64'h0000_0000_0000_0FFE;

  logic [SUB_N-1:0] perm_vec;
  logic [SUB_N-1:0] odd_vec;

  for (genvar i = 0; i < SUB_N; i++) begin : g_sub
    assign perm_vec[i] = entry[2*i];
    assign odd_vec[i]  = entry[2*i+1];
  end

  always_comb begin
    if (is_leaf) begin
      bad     = |odd_vec;
      present = 1'b1;
    end else begin
      bad     = |(entry & RSV_MASK);
      present = entry[0];
    end
  end

  assign perm      = perm_vec[sub_idx];
  assign next_base = entry[PA_W-1:12];
endmodule

// File: rtl/spg_walker.sv
module spg_walker
  import spg_pkg::*;
#(
  parameter int PA_W  = 46,
  parameter int GPA_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [PA_W-1:12]   cfg_root,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [GPA_W-1:0]   req_gpa,
  input  logic               req_write,
  input  logic               req_leaf_prot,
  input  logic               req_leaf_writable,
  input  logic               req_nmi_unblock,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  output logic               done,
  output logic [1:0]         result,
  output logic [63:0]        exit_qual,
  output logic [GPA_W-1:0]   fault_gpa
);
  localparam int IDX_TOP = 12 + LVL_N*IDX_W;
  localparam int SUB_LO  = 7;

  st_e                 state_q, state_n;
  logic [1:0]          lvl_q, lvl_n;
  logic [PA_W-13:0]    base_q, base_n;
  logic [GPA_W-1:0]    gpa_q;
  logic                nmi_q;
  res_e                res_q, res_n;
  logic                accept, bypass;
  res_e                bypass_res;
  logic                ent_bad, ent_present, ent_perm;
  logic [PA_W-13:0]    ent_next;
  logic                fault;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign bypass        = !req_write || !cfg_enable || !req_leaf_prot || req_leaf_writable;
  assign bypass_res    = (!req_write || req_leaf_writable) ? RES_ALLOW : RES_VIOL;
  assign mem_req_valid = (state_q == ST_ISSUE);

  spg_entry_addr #(.PA_W(PA_W)) u_addr (
    .base       (base_q),
    .level      (lvl_q),
    .idx_src    (gpa_q[IDX_TOP-1:12]),
    .entry_addr (mem_req_addr)
  );

  spg_entry_check #(.PA_W(PA_W)) u_chk (
    .entry     (mem_rsp_data),
    .is_leaf   (lvl_q == 2'd0),
    .sub_idx   (gpa_q[SUB_LO +: SUB_W]),
    .bad       (ent_bad),
    .present   (ent_present),
    .perm      (ent_perm),
    .next_base (ent_next)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    lvl_n   = lvl_q;
    base_n  = base_q;
    res_n   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (bypass) begin
            state_n = ST_DONE;
            res_n   = bypass_res;
          end else begin
            state_n = ST_ISSUE;
            lvl_n   = 2'd3;
            base_n  = cfg_root;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (ent_bad) begin
            state_n = ST_DONE;
            res_n   = RES_MISCFG;
          end else if (!ent_present) begin
            state_n = ST_DONE;
            res_n   = RES_MISS;
          end else if (lvl_q == 2'd0) begin
            state_n = ST_DONE;
            res_n   = ent_perm ? RES_ALLOW : RES_VIOL;
          end else begin
            state_n = ST_ISSUE;
            lvl_n   = lvl_q - 2'd1;
            base_n  = ent_next;
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= 2'd0;
      base_q  <= '0;
      res_q   <= RES_ALLOW;
    end else begin
      state_q <= state_n;
      lvl_q   <= lvl_n;
      base_q  <= base_n;
      res_q   <= res_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpa_q <= '0;
      nmi_q <= 1'b0;
    end else if (accept) begin
      gpa_q <= req_gpa;
      nmi_q <= req_nmi_unblock;
    end
  end

  // outputs
  assign done   = (state_q == ST_DONE);
  assign result = res_q;
  assign fault  = done && (res_q == RES_MISS || res_q == RES_MISCFG);

  always_comb begin
    exit_qual = '0;
    if (fault) begin
      exit_qual[Q_MISS] = (res_q == RES_MISS);
      exit_qual[Q_NMI]  = nmi_q;
    end
  end
  assign fault_gpa = fault ? gpa_q : '0;

  // assertions
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
  AST_NO_READY_WHILE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R9
  AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (!req_write || !cfg_enable || !req_leaf_prot || req_leaf_writable))
      |=> (done && !mem_req_valid)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_QUAL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_MISS) |-> exit_qual[Q_MISS]); // R8
  AST_QUAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((exit_qual & ~((64'd1 << Q_MISS) | (64'd1 << Q_NMI))) == 64'd0)); // R8
  AST_QUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[1] == 1'b0) |-> (exit_qual == 64'd0 && fault_gpa == '0)); // R8
endmodule

// File: tb/tb_spg_walker.sv
`timescale 1ns/1ps
module tb_spg_walker;
  localparam int PA_W  = 46;
  localparam int GPA_W = 48;
  localparam logic [63:0] ROOT = 64'h0000_1234_5000;
  localparam logic [63:0] T3   = 64'h0000_2000_1000;
  localparam logic [63:0] T2   = 64'h0000_2000_7000;
  localparam logic [63:0] T1   = 64'h0000_2abc_d000;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_enable;
  logic [PA_W-1:12] cfg_root;
  logic req_valid, req_ready, req_write, req_leaf_prot, req_leaf_writable, req_nmi_unblock;
  logic [GPA_W-1:0] req_gpa;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic done;
  logic [1:0] result;
  logic [63:0] exit_qual;
  logic [GPA_W-1:0] fault_gpa;

  int n_chk = 0;
  int n_bad = 0;
  int lat_a = 0;
  int lat_b = 0;
  int rd_cnt = 0;
  logic [63:0] rd_addr [8];
  bit [63:0] tbl [bit [63:0]];

  always #5 clk = ~clk;

  spg_walker #(.PA_W(PA_W), .GPA_W(GPA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_root(cfg_root),
    .req_valid(req_valid), .req_ready(req_ready), .req_gpa(req_gpa),
    .req_write(req_write), .req_leaf_prot(req_leaf_prot),
    .req_leaf_writable(req_leaf_writable), .req_nmi_unblock(req_nmi_unblock),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .result(result),
    .exit_qual(exit_qual), .fault_gpa(fault_gpa)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one outstanding read, programmable latency
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [63:0] a;
        repeat (lat_a) @(negedge clk);
        a = 64'(mem_req_addr);
        if (rd_cnt < 8) rd_addr[rd_cnt] = a;
        rd_cnt++;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat_b) @(negedge clk);
        mem_rsp_data  = tbl.exists(a) ? tbl[a] : 64'd0;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  function automatic logic [63:0] ent_addr(input logic [63:0] tb, input logic [47:0] g, input int lvl);
    return tb + 64'(g[12 + 9*lvl +: 9]) * 64'd8;
  endfunction

  function automatic logic [63:0] spread(input logic [31:0] m);
    logic [63:0] e = '0;
    for (int i = 0; i < 32; i++) e[2*i] = m[i];
    return e;
  endfunction

  task automatic build(input logic [47:0] g, input logic [63:0] e4, e3, e2, e1);
    tbl.delete();
    tbl[ent_addr(ROOT, g, 3)] = e4;
    tbl[ent_addr(T3,   g, 2)] = e3;
    tbl[ent_addr(T2,   g, 1)] = e2;
    tbl[ent_addr(T1,   g, 0)] = e1;
  endtask

  // one request; checks result, qualification, address, read count, pulse width
  task automatic run(input string tag, input logic [47:0] g, input bit wr, prot, wrb, nmi,
                     input logic [1:0] exp_res, input int exp_rd);
    logic [63:0] eq;
    bit fault;
    rd_cnt = 0;
    @(negedge clk);
    req_gpa = g; req_write = wr; req_leaf_prot = prot;
    req_leaf_writable = wrb; req_nmi_unblock = nmi; req_valid = 1'b1;
    chk({tag, " R9 ready idle"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_rd > 0) chk({tag, " R9 busy not ready"}, 64'(req_ready), 64'd0);
    while (!done) @(negedge clk);
    fault = exp_res[1];
    eq = '0;
    if (fault) begin
      eq[11] = (exp_res == 2'd2);
      eq[12] = nmi;
    end
    chk({tag, " result"}, 64'(result), 64'(exp_res));
    chk({tag, " R8 exit_qual"}, exit_qual, eq);
    chk({tag, " R8 fault_gpa"}, 64'(fault_gpa), fault ? 64'(g) : 64'd0);
    chk({tag, " reads"}, 64'(rd_cnt), 64'(exp_rd));
    @(negedge clk);
    chk({tag, " R10 done pulse"}, 64'(done), 64'd0);
  endtask

  localparam logic [47:0] G1 = 48'h7F3A_C5D2_1B80;   // sub-page 23
  localparam logic [47:0] G2 = 48'h0123_4567_8F80;   // sub-page 31

  task automatic t_reset();
    chk("R9 reset ready", 64'(req_ready), 64'd1);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R9 reset mem idle", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_bypass();
    build(G1, T3 | 1, T2 | 1, T1 | 1, spread(32'h0));
    run("R1 read", G1, 0, 1, 0, 0, 2'd0, 0);
    cfg_enable = 1'b0;
    run("R1 disabled write", G1, 1, 1, 0, 0, 2'd1, 0);
    cfg_enable = 1'b1;
    run("R1 flag clear writable", G1, 1, 0, 1, 0, 2'd0, 0);
    run("R1 flag clear readonly", G1, 1, 0, 0, 1, 2'd1, 0);
    run("R2 writable skip", G1, 1, 1, 1, 0, 2'd0, 0);
  endtask

  task automatic t_walk_allow();
    lat_a = 0; lat_b = 0;
    build(G1, T3 | 1, T2 | 1, T1 | 1, spread(32'h0080_0000));
    run("R7 allow", G1, 1, 1, 0, 0, 2'd0, 4);
    chk("R3 addr L4", rd_addr[0], ent_addr(ROOT, G1, 3));
    chk("R3 addr L3", rd_addr[1], ent_addr(T3, G1, 2));
    chk("R3 addr L2", rd_addr[2], ent_addr(T2, G1, 1));
    chk("R3 addr L1", rd_addr[3], ent_addr(T1, G1, 0));
  endtask

  task automatic t_walk_viol();
    lat_a = 3; lat_b = 2;
    build(G2, T3 | 1, T2 | 1, T1 | 1, spread(32'h7FFF_FFFF));
    run("R7 violation", G2, 1, 1, 0, 1, 2'd1, 4);
    chk("R3 addr L1 G2", rd_addr[3], ent_addr(T1, G2, 0));
  endtask

  task automatic t_faults();
    lat_a = 1; lat_b = 4;
    build(G1, T3 | 1, 64'h0, T2 | 1, spread(32'hFFFF_FFFF));
    run("R5 miss L3", G1, 1, 1, 0, 1, 2'd2, 2);
    build(G2, T3 | 1, T2 | 1, T2 | 64'h3, spread(32'hFFFF_FFFF));
    run("R4 low reserved L2", G2, 1, 1, 0, 0, 2'd3, 3);
    build(G1, 64'h8000_0000_0000_0000, T2 | 1, T1 | 1, spread(32'hFFFF_FFFF));
    run("R4 reserved beats absent L4", G1, 1, 1, 0, 1, 2'd3, 1);
    build(G2, T3 | 1, T2 | 1 | (64'd1 << PA_W), T1 | 1, spread(32'hFFFF_FFFF));
    run("R4 bit PA_W L3", G2, 1, 1, 0, 0, 2'd3, 2);
    build(G1, T3 | 1, T2 | 1, T1 | 1, spread(32'hFFFF_FFFF) | 64'h0200_0000_0000_0000);
    run("R6 leaf odd bit", G1, 1, 1, 0, 0, 2'd3, 4);
    lat_a = 0; lat_b = 0;
    build(G2, 64'h0, T2 | 1, T1 | 1, spread(32'hFFFF_FFFF));
    run("R5 miss L4", G2, 1, 1, 0, 0, 2'd2, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b1;
    cfg_root = ROOT[PA_W-1:12];
    req_valid = 1'b0; req_gpa = '0; req_write = 1'b0;
    req_leaf_prot = 1'b0; req_leaf_writable = 1'b0; req_nmi_unblock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_walk_allow();
    t_walk_viol();
    t_faults();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule